// File: doc/BRIEF.md
# LPC Firmware Window Address Translator

This block sits between the host-facing LPC firmware/memory-cycle decoder and the management controller's internal bus master. Each host request address is tested against one remappable window. On a hit, the block forms an internal-bus address. It reports a miss otherwise. The translation runs in one combinational pass from host address to internal address. The only state is two configuration registers.

Translation works on 64 KiB pages. The low half of the address always passes straight through. Each upper address bit is built from two masks. One mask takes the bit from a programmed target value. The other mask takes it from the request. Because this is a per-bit merge and not an adder, a window only maps linearly when its target is aligned to its size. A misaligned target breaks the visible range into fragments.

The register bus is a plain single-cycle write strobe with a separate combinational read port. Firmware writes a window register and a mask register. All protocol handling, data movement and bus mastering live outside this block.

Top module: `lpcwin_xlate`

## Requirements
- R1: After reset both registers read zero. The block then hits only host addresses whose upper 16 bits are 0x0000, and maps them to internal addresses with upper 16 bits 0x0000.
- R2: A write strobe at byte offset 0x8 loads the window register; one at offset 0xC loads the mask register. The new value is visible on the read port, and used for translation, from the cycle after the strobe.
- R3: Writes to any other offset change neither register. Reads at any offset other than 0x8 or 0xC return zero.
- R4: In the window register, bits [15:0] hold the host page. A request hits when its address bits [31:16] equal that field in every position where mask bit [k] (k in 0..15) is 0.
- R5: On a hit, internal address bits [15:0] equal host address bits [15:0].
- R6: On a hit, for each k in 0..15, internal bit 16+k is the OR of two terms. The first is window bit 16+k when mask bit 16+k is 1. The second is host bit 16+k when mask bit k is 1. Each term is 0 when its mask bit is 0.
- R7: On a miss, the hit output is 0 and the internal address is all zeros.
- R8: A target aligned to a power-of-two window size maps the window linearly. A target offset that is not a multiple of the size is not shifted. It lands on the aligned page below, so the pages above the aligned end of the window are unreachable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | 4 | Write byte offset |
| cfg_wdata | input | 32 | Write data |
| cfg_raddr | input | 4 | Read byte offset |
| cfg_rdata | output | 32 | Read data (combinational) |
| host_addr | input | 32 | Host firmware-space request address |
| win_hit | output | 1 | Request falls in the window |
| bus_addr | output | 32 | Translated internal-bus address, zero on a miss |

## Verification
A wrong register bit shows up at the ports in the cycle after the write. It appears either on the read port or as a shifted hit range and corrupted upper address bits. A sweep of 512 consecutive host pages around each programmed window exposes it within the first vectors. A fault in the merge is confined to one upper address bit. It appears only for requests whose page differs in that bit, which is why each sweep crosses many page boundaries. The misaligned setting is checked at exact pages, so a design that adds an offset would be caught, not only one that fails to mask.

// File: rtl/lpcwin_pkg.sv
package lpcwin_pkg;
  localparam int CFG_AW = 4;
  localparam logic [CFG_AW-1:0] WIN_OFS  = 4'h8;
  localparam logic [CFG_AW-1:0] MASK_OFS = 4'hC;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_WIN  = 2'd1,
    SEL_MASK = 2'd2
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic [CFG_AW-1:0] ofs);
    if (ofs == WIN_OFS)       return SEL_WIN;
    else if (ofs == MASK_OFS) return SEL_MASK;
    else                      return SEL_NONE;
  endfunction
endpackage

// File: rtl/lpcwin_regs.sv
module lpcwin_regs
  import lpcwin_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_waddr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic [CFG_AW-1:0] cfg_raddr,
  output logic [ADDR_W-1:0] cfg_rdata,
  output logic [ADDR_W-1:0] win_q,
  output logic [ADDR_W-1:0] mask_q
);
  reg_sel_e wsel, rsel;

  always_comb begin
    wsel = cfg_we ? decode_sel(cfg_waddr) : SEL_NONE;
    rsel = decode_sel(cfg_raddr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q  <= '0;
      mask_q <= '0;
    end else begin
      if (wsel == SEL_WIN)  win_q  <= cfg_wdata;
      if (wsel == SEL_MASK) mask_q <= cfg_wdata;
    end
  end

  always_comb begin
    unique case (rsel)
      SEL_WIN:  cfg_rdata = win_q;
      SEL_MASK: cfg_rdata = mask_q;
      default:  cfg_rdata = '0;
    endcase
  end

  // R2: window register update lands one cycle after the strobe
  a_r2_win_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_waddr == WIN_OFS) |=> (win_q == $past(cfg_wdata)));
  // R2: mask register update lands one cycle after the strobe
  a_r2_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_waddr == MASK_OFS) |=> (mask_q == $past(cfg_wdata)));
  // R3: writes elsewhere leave both registers untouched
  a_r3_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_waddr != WIN_OFS && cfg_waddr != MASK_OFS)
      |=> ($stable(win_q) && $stable(mask_q)));
  // R1: registers are clear on leaving reset
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (win_q == '0 && mask_q == '0));
endmodule

// File: rtl/lpcwin_match.sv
module lpcwin_match #(
  parameter int PAGE_W = 16
) (
  input  logic [PAGE_W-1:0] req_page,
  input  logic [PAGE_W-1:0] host_page,
  input  logic [PAGE_W-1:0] keep_mask,
  output logic              hit
);
  function automatic logic page_match(input logic [PAGE_W-1:0] req,
                                      input logic [PAGE_W-1:0] ref_page,
                                      input logic [PAGE_W-1:0] dont_care);
    return (((req ^ ref_page) & ~dont_care) == '0);
  endfunction

  assign hit = page_match(req_page, host_page, keep_mask);
endmodule

// File: rtl/lpcwin_merge.sv
module lpcwin_merge #(
  parameter int PAGE_W = 16
) (
  input  logic [PAGE_W-1:0] req_page,
  input  logic [PAGE_W-1:0] tgt_page,
  input  logic [PAGE_W-1:0] repl_mask,
  input  logic [PAGE_W-1:0] keep_mask,
  output logic [PAGE_W-1:0] out_page
);
  for (genvar k = 0; k < PAGE_W; k++) begin : g_bit
    assign out_page[k] = (tgt_page[k] & repl_mask[k]) | (req_page[k] & keep_mask[k]);
  end
endmodule

// File: rtl/lpcwin_xlate.sv
module lpcwin_xlate
  import lpcwin_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_waddr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic [3:0]        cfg_raddr,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic [ADDR_W-1:0] host_addr,
  output logic              win_hit,
  output logic [ADDR_W-1:0] bus_addr
);
  localparam int PAGE_W = ADDR_W / 2;

  logic [ADDR_W-1:0] win_q, mask_q;
  logic [PAGE_W-1:0] req_page, tgt_page, host_page, repl_mask, keep_mask;
  logic [PAGE_W-1:0] merged_page;
  logic              match_hit;

  lpcwin_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
    .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .win_q(win_q), .mask_q(mask_q)
  );

  assign req_page  = host_addr[ADDR_W-1:PAGE_W];
  assign tgt_page  = win_q[ADDR_W-1:PAGE_W];
  assign host_page = win_q[PAGE_W-1:0];
  assign repl_mask = mask_q[ADDR_W-1:PAGE_W];
  assign keep_mask = mask_q[PAGE_W-1:0];

  lpcwin_match #(.PAGE_W(PAGE_W)) u_match (
    .req_page(req_page), .host_page(host_page),
    .keep_mask(keep_mask), .hit(match_hit)
  );

  lpcwin_merge #(.PAGE_W(PAGE_W)) u_merge (
    .req_page(req_page), .tgt_page(tgt_page),
    .repl_mask(repl_mask), .keep_mask(keep_mask), .out_page(merged_page)
  );

  assign win_hit  = match_hit;
  assign bus_addr = match_hit ? {merged_page, host_addr[PAGE_W-1:0]} : '0;

  // R7: a miss drives a zero internal address
  a_r7_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !win_hit |-> (bus_addr == '0));
  // R5: offset within the page survives translation
  a_r5_low_pass: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> (bus_addr[PAGE_W-1:0] == host_addr[PAGE_W-1:0]));
  // R1: with both registers clear only page zero hits, and maps to page zero
  a_r1_default_window: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q == '0 && mask_q == '0 && win_hit) |-> (bus_addr[ADDR_W-1:PAGE_W] == '0));
endmodule

// File: tb/tb_lpcwin_xlate.sv
module tb_lpcwin_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_waddr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  cfg_raddr = '0;
  logic [31:0] cfg_rdata;
  logic [31:0] host_addr = '0;
  logic        win_hit;
  logic [31:0] bus_addr;

  int n_chk = 0, n_bad = 0, cycles = 0;
  logic [31:0] sh_win = '0, sh_mask = '0;

  always #2 clk = ~clk;

  lpcwin_xlate dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr),
    .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .host_addr(host_addr), .win_hit(win_hit), .bus_addr(bus_addr)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Reference model written bit by bit from R4 and R6
  task automatic model(input logic [31:0] w, input logic [31:0] m, input logic [31:0] h,
                       output logic e_hit, output logic [31:0] e_addr);
    e_hit = 1'b1;
    e_addr = {16'h0, h[15:0]};
    for (int k = 0; k < 16; k++) begin
      if (!m[k] && (h[16+k] != w[k])) e_hit = 1'b0;
      if (m[16+k] && w[16+k]) e_addr[16+k] = 1'b1;
      if (m[k] && h[16+k])    e_addr[16+k] = 1'b1;
    end
    if (!e_hit) e_addr = '0;
  endtask

  task automatic wr(input logic [3:0] ofs, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_waddr = ofs; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (ofs == 4'h8) sh_win = d;
    if (ofs == 4'hC) sh_mask = d;
  endtask

  task automatic rd(input string req, input logic [3:0] ofs, input logic [31:0] exp);
    @(negedge clk);
    cfg_raddr = ofs;
    #1 chk(req, cfg_rdata, exp);
  endtask

  task automatic probe(input string req, input logic [31:0] h, input logic e_hit, input logic [31:0] e_addr);
    @(negedge clk);
    host_addr = h;
    #1;
    chk(req, {31'h0, win_hit}, {31'h0, e_hit});
    chk(req, bus_addr, e_addr);
  endtask

  // Sweep 512 consecutive pages around the programmed host page (R4 R5 R6 R7)
  task automatic sweep(input string req);
    logic        eh;
    logic [31:0] ea;
    logic [15:0] pg;
    for (int j = 0; j < 512; j++) begin
      pg = sh_win[15:0] - 16'd256 + j[15:0];
      @(negedge clk);
      host_addr = {pg, 16'(j * 40503 + 7)};
      #1;
      model(sh_win, sh_mask, host_addr, eh, ea);
      chk(req, {31'h0, win_hit}, {31'h0, eh});
      chk(req, bus_addr, ea);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd("R1 win reset", 4'h8, 32'h0);
    rd("R1 mask reset", 4'hC, 32'h0);
    probe("R1 page0 hit", 32'h0000_BEEF, 1'b1, 32'h0000_BEEF);
    probe("R1 page1 miss", 32'h0001_0000, 1'b0, 32'h0);
    sweep("R1 reset sweep");

    // R2 register load and readback
    wr(4'h8, 32'h8020_0FF0);
    wr(4'hC, 32'hFFF0_000F);
    rd("R2 win readback", 4'h8, 32'h8020_0FF0);
    rd("R2 mask readback", 4'hC, 32'hFFF0_000F);
    sweep("R4 R6 aligned 1MiB sweep");
    // R8 aligned: linear mapping
    probe("R8 aligned first page", 32'h0FF0_1234, 1'b1, 32'h8020_1234);
    probe("R8 aligned last page", 32'h0FFF_FFFF, 1'b1, 32'h802F_FFFF);
    probe("R7 below window", 32'h0FEF_FFFF, 1'b0, 32'h0);

    // R3 stray writes ignored, stray reads return zero
    wr(4'h0, 32'hFFFF_FFFF);
    wr(4'h4, 32'hFFFF_FFFF);
    wr(4'h9, 32'hFFFF_FFFF);
    rd("R3 win kept", 4'h8, 32'h8020_0FF0);
    rd("R3 mask kept", 4'hC, 32'hFFF0_000F);
    rd("R3 read other", 4'h4, 32'h0);
    probe("R3 translation kept", 32'h0FF5_0010, 1'b1, 32'h8025_0010);

    // R8 misaligned: 4-page window, target offset 2 pages into 0x0100
    wr(4'h8, 32'h0102_0040);
    wr(4'hC, 32'hFFFC_0003);
    probe("R8 misaligned start not shifted", 32'h0040_0000, 1'b1, 32'h0100_0000);
    probe("R8 misaligned third page", 32'h0042_0000, 1'b1, 32'h0102_0000);
    probe("R8 misaligned top page", 32'h0043_0000, 1'b1, 32'h0103_0000);
    sweep("R8 misaligned sweep");
    // R8 aligned counterpart
    wr(4'h8, 32'h0104_0040);
    probe("R8 aligned start", 32'h0040_0000, 1'b1, 32'h0104_0000);
    probe("R8 aligned top", 32'h0043_0000, 1'b1, 32'h0107_0000);

    // Gapped keep mask: scattered hits
    wr(4'h8, 32'h0000_0000);
    wr(4'hC, 32'hFFFD_0002);
    probe("R4 gap page1 miss", 32'h0001_0000, 1'b0, 32'h0);
    probe("R6 gap page2 hit", 32'h0002_0044, 1'b1, 32'h0002_0044);
    sweep("R4 R6 gapped sweep");

    // Overlapping masks: OR of both terms
    wr(4'h8, 32'hA5A5_1234);
    wr(4'hC, 32'h0F0F_00FF);
    sweep("R6 overlap sweep");
    wr(4'hC, 32'hFFFF_FFFF);
    sweep("R6 full-keep sweep");

    // R1 again after a second reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    sh_win = '0; sh_mask = '0;
    rd("R1 win after reset", 4'h8, 32'h0);
    rd("R1 mask after reset", 4'hC, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule